// File: doc/BRIEF.md
# Transform Output Scaler and Natural-Order Reorder

This block is the back end of a 64-point radix-4 transform pipeline. The last butterfly stage hands it 15-bit complex results in base-4 digit-reversed order, one per clock, framed by a valid flag. The block turns each block of 64 results into natural order. It uses two buffer banks that alternate: one fills while the other drains.

On the way out, each result is cut down to 12 bits by a 2-bit window select. Anything that the chosen window cannot hold is clamped. The output stream is framed by three flags. An enable flag is high across the 64 samples. A start strobe covers the first two samples. An overflow flag latches from the first clipped sample to the end of that block.

Input blocks may follow one another with no idle cycles, or with gaps inside or between them. A block's output begins one clock after its last input sample is accepted.

Top module: `out_reorder_scaler`

## Requirements
- R1: The input sample accepted at position p (0..63 within its block) carries the result with natural index q. q is p with its three base-4 digits (bit pairs [1:0], [3:2], [5:4]) in reverse order. Outputs leave in ascending q.
- R2: Window select 0 outputs bits [14:3] of the result, 1 outputs [13:2], 2 outputs [12:1] and 3 outputs [11:0]. Bits below the window are truncated without rounding.
- R3: When the truncated value exceeds +2047 it is output as +2047. When it is below -2048 it is output as -2048. I and Q are clamped independently.
- R4: The overflow flag rises on the first sample of a block in which I or Q was clamped. It stays high to the end of that block and is low on the first sample of the next block unless that sample clips. It is low whenever the enable flag is low.
- R5: The enable flag is high for exactly 64 consecutive cycles per block.
- R6: The start strobe is high on the first two samples of each block only.
- R7: A block's first output sample appears on the clock edge after the edge that accepts its last input sample. Back-to-back input blocks give an unbroken enable flag.
- R8: Cycles with the input valid flag low are ignored. A block may be spread over any number of cycles.
- R9: The window select is sampled only in the cycle that accepts a block's last input sample, and it applies to that whole output block.
- R10: Reset is asynchronous and active high. It clears all output flags and data to zero and restarts the input position at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_re | input | 15 | Real part of result, two's complement, digit-reversed order |
| in_im | input | 15 | Imaginary part of result, two's complement |
| shift_sel | input | 2 | Output window select |
| out_en | output | 1 | Output block enable |
| out_sof | output | 1 | Start-of-block strobe (first two samples) |
| out_ovf | output | 1 | Sticky per-block overflow flag |
| out_re | output | 12 | Real output, natural order |
| out_im | output | 12 | Imaginary output, natural order |

## Verification
Output sample k of a block is due k+1 cycles after the edge that accepts that block's last input sample. The bench records the cycle of that edge for every block and compares it with the cycle in which the enable flag first shows the block. All output is sampled on the falling edge.

Data, strobe and overflow are checked every cycle of every block against a model built from the requirement formulas. The sweep covers all four window selects, small, wide and single-spike data, back-to-back blocks, idle gaps between blocks and random holes inside blocks. In the holes the window select and data are driven with noise, so any use of them outside the sampling cycle shows up in the results.

// File: rtl/out_reorder_scaler.sv
module out_reorder_scaler #(
  parameter int DIGITS = 3,
  parameter int IN_W   = 15,
  parameter int OUT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  input  logic [1:0]       shift_sel,
  output logic             out_en,
  output logic             out_sof,
  output logic             out_ovf,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im
);
  localparam int AW       = 2 * DIGITS;
  localparam int N        = 1 << AW;
  localparam int DROP_MAX = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic [AW-1:0] digit_rev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int d = 0; d < DIGITS; d++) r[2*d +: 2] = a[2*(DIGITS-1-d) +: 2];
    return r;
  endfunction

  function automatic logic [OUT_W:0] scale(input logic [IN_W-1:0] v, input logic [1:0] sel);
    logic signed [IN_W-1:0] t;
    logic [IN_W-OUT_W:0] hi;
    t  = $signed(v) >>> (DROP_MAX - int'(sel));
    hi = t[IN_W-1:OUT_W-1];
    if ((&hi) || !(|hi)) return {1'b0, t[OUT_W-1:0]};
    return {1'b1, t[IN_W-1] ? NEG_MAX : POS_MAX};
  endfunction

  logic [2*IN_W-1:0] bank [2][N];
  logic [AW-1:0] wcnt, rd_cnt;
  logic          wbank, rd_bank, rd_active;
  logic [1:0]    sel_q;

  wire last_in = in_valid && (wcnt == AW'(N-1));

  always_ff @(posedge clk)
    if (in_valid) bank[wbank][digit_rev(wcnt)] <= {in_re, in_im};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wcnt <= '0; wbank <= 1'b0;
      rd_active <= 1'b0; rd_bank <= 1'b0; rd_cnt <= '0; sel_q <= '0;
    end else begin
      if (in_valid) wcnt <= wcnt + 1'b1;
      if (last_in) begin
        wbank     <= ~wbank;
        rd_active <= 1'b1;
        rd_bank   <= wbank;
        rd_cnt    <= '0;
        sel_q     <= shift_sel;
      end else if (rd_active) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_cnt == AW'(N-1)) rd_active <= 1'b0;
      end
    end
  end

  logic [2*IN_W-1:0] rd_word;
  logic [OUT_W:0]    s_re, s_im;
  assign rd_word = bank[rd_bank][rd_cnt];
  assign s_re    = scale(rd_word[2*IN_W-1:IN_W], sel_q);
  assign s_im    = scale(rd_word[IN_W-1:0], sel_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_en <= 1'b0; out_sof <= 1'b0; out_ovf <= 1'b0;
      out_re <= '0;   out_im  <= '0;
    end else begin
      out_en  <= rd_active;
      out_sof <= rd_active && (rd_cnt < AW'(2));
      out_ovf <= rd_active && ((rd_cnt != '0 && out_ovf) || s_re[OUT_W] || s_im[OUT_W]);
      out_re  <= rd_active ? s_re[OUT_W-1:0] : '0;
      out_im  <= rd_active ? s_im[OUT_W-1:0] : '0;
    end
  end
endmodule

module out_reorder_scaler_chk #(
  parameter int DIGITS = 3,
  parameter int OUT_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             out_en,
  input logic             out_sof,
  input logic             out_ovf,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  localparam int AW = 2 * DIGITS;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic [AW-1:0] pos;
  always_ff @(posedge clk or posedge rst)
    if (rst) pos <= '0;
    else if (out_en) pos <= pos + 1'b1;

  // R5
  en_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(out_en) |-> pos == '0);
  // R6
  sof_first_chk: assert property (@(posedge clk) disable iff (rst) (out_en && pos == '0) |-> out_sof);
  // R6
  sof_late_chk: assert property (@(posedge clk) disable iff (rst) (out_sof) |-> (out_en && pos < AW'(2)));
  // R4
  ovf_en_chk: assert property (@(posedge clk) disable iff (rst) out_ovf |-> out_en);
  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_en && pos != '0 && $past(out_ovf)) |-> out_ovf);
  // R3
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_ovf) |-> (out_re == POS_MAX || out_re == NEG_MAX || out_im == POS_MAX || out_im == NEG_MAX));
endmodule

bind out_reorder_scaler out_reorder_scaler_chk #(.DIGITS(DIGITS), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .out_en(out_en), .out_sof(out_sof), .out_ovf(out_ovf),
  .out_re(out_re), .out_im(out_im));

// File: tb/out_reorder_scaler_bench.sv
module out_reorder_scaler_bench;
  localparam int NB = 12;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [14:0] in_re = '0, in_im = '0;
  logic [1:0]  shift_sel = '0;
  logic out_en, out_sof, out_ovf;
  logic [11:0] out_re, out_im;

  out_reorder_scaler u_out_reorder_scaler (.*);

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, failures = 0;
  int nat_re [NB][64];
  int nat_im [NB][64];
  int t_last [NB];
  int blk_out = 0, k = 0;
  bit m_ovf = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gen(input int b, input int q, input int im);
    case (b % 3)
      0: return ((q*37 + b*11 + im*5) % 511) - 255;
      1: return ((q*1237 + b*4099 + im*2731) % 32768) - 16384;
      default: return (q == (5 + b) % 64) ? (im != 0 ? -16000 : 14000) : ((q*3 + im) % 64) - 32;
    endcase
  endfunction

  function automatic int rev4(input int p);
    return (p % 4) * 16 + ((p / 4) % 4) * 4 + p / 16;
  endfunction

  // returns clamped value; sets ov
  function automatic int model(input int v, input int s, output bit ov);
    int t;
    t = v >>> (3 - s);
    ov = 0;
    if (t > 2047) begin t = 2047; ov = 1; end
    else if (t < -2048) begin t = -2048; ov = 1; end
    return t;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (out_en && blk_out < NB) begin
        bit ovr, ovi;
        int er, ei, s;
        s  = blk_out % 4;
        er = model(nat_re[blk_out][k], s, ovr);
        ei = model(nat_im[blk_out][k], s, ovi);
        m_ovf = (k == 0 ? 1'b0 : m_ovf) | ovr | ovi;
        if (k == 0) chk(cyc == t_last[blk_out] + 1, "R7 first output timing", cyc, t_last[blk_out] + 1);
        chk($signed(out_re) == er, "R1 R2 R3 I data", $signed(out_re), er);
        chk($signed(out_im) == ei, "R1 R2 R3 Q data", $signed(out_im), ei);
        chk(out_sof == (k < 2), "R6 start strobe", out_sof, k < 2);
        chk(out_ovf == m_ovf, "R4 overflow flag", out_ovf, m_ovf);
        k++;
        if (k == 64) begin k = 0; blk_out++; end
      end else begin
        if (k != 0) chk(1'b0, "R5 enable dropped mid-block", k, 64);
        if (out_sof || out_ovf) chk(1'b0, "R4 R6 flags while idle", {out_sof, out_ovf}, 0);
      end
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int q = 0; q < 64; q++) begin
        nat_re[b][q] = gen(b, q, 0);
        nat_im[b][q] = gen(b, q, 1);
      end
    repeat (3) @(negedge clk);
    // R10
    chk(out_en == 0 && out_sof == 0 && out_ovf == 0, "R10 reset flags", {out_en, out_sof, out_ovf}, 0);
    chk(out_re == 0 && out_im == 0, "R10 reset data", out_re, 0);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (b == 4) begin in_valid = 1'b0; repeat (20) @(negedge clk); end
      for (int p = 0; p < 64; p++) begin
        // R8: holes with noise on data and select
        while (b % 4 == 3 && ($urandom % 5) == 0) begin
          in_valid = 1'b0;
          in_re = 15'($urandom); in_im = 15'($urandom); shift_sel = 2'($urandom);
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_re = 15'(nat_re[b][rev4(p)]);
        in_im = 15'(nat_im[b][rev4(p)]);
        // R9: select only valid on the last sample
        shift_sel = (p == 63) ? 2'(b % 4) : 2'($urandom);
        if (p == 63) t_last[b] = cyc + 1;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    for (int w = 0; w < 2000 && blk_out < NB; w++) @(negedge clk);
    if (blk_out < NB) chk(1'b0, "R5 watchdog blocks out", blk_out, NB);
    repeat (3) @(negedge clk);
    chk(out_en == 0, "R5 enable low after last block", out_en, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule